// File: doc/BRIEF.md
# LPC Address Window Mapper and Splitter

This block takes host cycle requests aimed at one of three LPC address spaces (I/O, memory or firmware) and turns them into accesses on a flat 32-bit internal bus. Each request carries a space code, a start address, a size of 1, 2 or 4 bytes, a direction and write data. The block checks the request against the limits of its space and rejects it with a parameter-error status if it does not fit. A request that passes is rebased into that space's internal window and issued over a simple request/acknowledge bus.

I/O and memory cycles wider than a byte go out as a run of single-byte accesses. Read bytes are packed back into one word, and a failing byte stops the run. Firmware space is divided into 256 MB banks. A 4-bit bank select and a firmware read-width setting live in controller registers on the same internal bus. Both are cached in the block and are only reprogrammed when a request needs a different value.

Top module: `lpc_window_mapper`

## Requirements
- R1: After reset `busy`, `rsp_valid` and `bus_req` are low. The bank-select and read-width caches hold an invalid value, so the first firmware read programs both registers.
- R2: Space code 0 (I/O) accepts a request only when address plus size is at most 0x10000. Its accesses go to internal address 0xD0010000 plus the request address.
- R3: Space code 1 (memory) accepts a request only when address plus size is at most 0x10000000. Its accesses go to internal address 0xE0000000 plus the request address.
- R4: Space code 2 (firmware) issues one access of the full request size to 0xF0000000 plus address bits 27:0. The request is rejected when its first and last byte have different address bits 31:28.
- R5: Any request whose address plus size exceeds 2^32 - 1 is rejected.
- R6: A rejected request gets `rsp_status` 1 two cycles after acceptance and makes no bus access. Rejected requests include space code 3, any size other than 1, 2 or 4, and the cases in R2 to R5.
- R7: When a firmware request's bank (address bits 31:28) differs from the cached bank, the block first reads the register at 0xC0012024. It then writes that register back with bits 31:4 kept and bits 3:0 set to the new bank. With a matching cache, no register access occurs.
- R8: Before a firmware read whose size differs from the cached read width, the block writes 0xC0012028 with a size code in bits 27:24: code 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes. Firmware writes never touch this register or its cache.
- R9: A multi-byte I/O or memory write is issued as size-1 writes to ascending addresses. Each carries one data byte in bits 7:0, starting with the least significant byte.
- R10: A multi-byte I/O or memory read is issued as size-1 reads to ascending addresses. The byte from the lowest address lands in the most significant byte of the result. A firmware read returns the low size bytes of the bus data, zero-extended. Writes return zero data.
- R11: A bus access acknowledged with `bus_err` ends the request at once with `rsp_status` 2 and no further accesses. A failed register write leaves its cache unchanged.
- R12: `bus_req`, `bus_addr` and `bus_write` stay stable until `bus_ack`. `rsp_valid` is a single-cycle pulse. `req_valid` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_space | input | 2 | 0 I/O, 1 memory, 2 firmware, 3 illegal |
| req_addr | input | 32 | Request start address |
| req_size | input | 3 | Size in bytes (1, 2 or 4) |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data, right-justified |
| busy | output | 1 | A request is in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 0 ok, 1 parameter error, 2 bus error |
| rsp_rdata | output | 32 | Read result, right-justified |
| bus_req | output | 1 | Internal bus access request |
| bus_write | output | 1 | Internal access direction |
| bus_addr | output | 32 | Internal access address |
| bus_size | output | 3 | Internal access size in bytes |
| bus_wdata | output | 32 | Internal write data |
| bus_ack | input | 1 | Access completion pulse |
| bus_err | input | 1 | Error flag, valid with `bus_ack` |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |

## Verification
Two events can land in the same cycle. When a bank-select write is acknowledged, the bank cache is updated. On that same edge the block decides, from the read-width cache, whether a width write must follow. The bench provokes this with firmware reads that change the bank alone, the width alone, or both. It judges the result by the exact list of register and data accesses seen on the bus. A second overlap is a new `req_valid` pulse while a split read is still running. This case is judged by confirming that only the bytes of the first request reach the bus and that exactly one response appears.

// File: rtl/lpc_map_pkg.sv
// Shared encodings for the LPC window mapper.
// Assumes sizes are expressed in bytes (1, 2 or 4).
package lpc_map_pkg;

    typedef enum logic [1:0] {
        SP_IO  = 2'd0,
        SP_MEM = 2'd1,
        SP_FW  = 2'd2,
        SP_BAD = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        RS_OK    = 2'd0,
        RS_PARAM = 2'd1,
        RS_BUS   = 2'd2
    } rsp_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_SEG_RD,
        S_SEG_WR,
        S_RSZ_WR,
        S_DATA,
        S_RESP
    } fsm_e;

    // Read-width code for the firmware read-width register.
    function automatic logic [3:0] rsz_code(input logic [2:0] sz);
        case (sz)
            3'd1:    rsz_code = 4'd0;
            3'd2:    rsz_code = 4'd1;
            default: rsz_code = 4'd2;
        endcase
    endfunction

endpackage

// File: rtl/lpc_window_check.sv
// Bounds checker and address rebaser for one request.
// Purely combinational; assumes inputs are held stable by the caller.
module lpc_window_check
    import lpc_map_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SZ_W      = 3,
    parameter int SEG_SHIFT = 28,
    parameter logic [ADDR_W-1:0] IO_BASE  = 32'hD001_0000,
    parameter logic [ADDR_W-1:0] MEM_BASE = 32'hE000_0000,
    parameter logic [ADDR_W-1:0] FW_BASE  = 32'hF000_0000,
    parameter logic [ADDR_W:0]   IO_LIMIT  = 33'h0_0001_0000,
    parameter logic [ADDR_W:0]   MEM_LIMIT = 33'h0_1000_0000
) (
    input  logic [1:0]        space,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SZ_W-1:0]   size,
    output logic              ok,
    output logic [ADDR_W-1:0] map_addr
);
    localparam int SEG_W = ADDR_W - SEG_SHIFT;

    logic [ADDR_W:0]   top;
    logic [ADDR_W-1:0] last;
    logic              size_ok;
    logic              wrap;

    // End address with carry, and the address of the final byte.
    always_comb begin
        top     = {1'b0, addr} + (ADDR_W+1)'(size);
        last    = addr + ADDR_W'(size) - ADDR_W'(1);
        wrap    = top[ADDR_W];
        size_ok = (size == SZ_W'(1)) || (size == SZ_W'(2)) || (size == SZ_W'(4));
    end

    // Space-specific acceptance and rebasing.
    always_comb begin
        ok       = 1'b0;
        map_addr = '0;
        case (space_e'(space))
            SP_IO: begin
                ok       = size_ok && !wrap && (top <= IO_LIMIT);
                map_addr = IO_BASE + addr;
            end
            SP_MEM: begin
                ok       = size_ok && !wrap && (top <= MEM_LIMIT);
                map_addr = MEM_BASE + addr;
            end
            SP_FW: begin
                ok       = size_ok && !wrap &&
                           (last[ADDR_W-1 -: SEG_W] == addr[ADDR_W-1 -: SEG_W]);
                map_addr = FW_BASE + {{SEG_W{1'b0}}, addr[SEG_SHIFT-1:0]};
            end
            default: begin
                ok       = 1'b0;
                map_addr = '0;
            end
        endcase
    end
endmodule

// File: rtl/lpc_fw_cache.sv
// Holds the last programmed firmware bank and read width.
// Assumes update strobes fire only after a successful register write.
module lpc_fw_cache #(
    parameter int SEG_W   = 4,
    parameter int SZ_W    = 3,
    parameter int CACHE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEG_W-1:0] seg_req,
    input  logic [SZ_W-1:0]  rsz_req,
    input  logic             seg_set,
    input  logic             rsz_set,
    output logic             seg_hit,
    output logic             rsz_hit
);
    localparam logic [CACHE_W-1:0] INVALID = '1;

    logic [CACHE_W-1:0] seg_q;
    logic [CACHE_W-1:0] rsz_q;

    // Cache registers: invalid after reset, loaded on confirmed writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q <= INVALID;
            rsz_q <= INVALID;
        end else begin
            if (seg_set) seg_q <= CACHE_W'(seg_req);
            if (rsz_set) rsz_q <= CACHE_W'(rsz_req);
        end
    end

    // Compare the requested settings with the cached ones.
    always_comb begin
        seg_hit = (seg_q == CACHE_W'(seg_req));
        rsz_hit = (rsz_q == CACHE_W'(rsz_req));
    end

    // Bank cache holds either the invalid marker or a 4-bit bank.
    assert_seg_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_q == INVALID) || (seg_q < CACHE_W'(16)));

    // Width cache holds either the invalid marker or a byte count of 1, 2 or 4.
    assert_rsz_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsz_q == INVALID) || (rsz_q == CACHE_W'(1)) ||
        (rsz_q == CACHE_W'(2)) || (rsz_q == CACHE_W'(4)));
endmodule

// File: rtl/lpc_byte_seq.sv
// Byte index counter and read-data assembler for split and single accesses.
// Assumes clear precedes every request and step never passes the last byte.
module lpc_byte_seq #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2,
    parameter int SZ_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic              capture,
    input  logic              load,
    input  logic [SZ_W-1:0]   size,
    input  logic [DATA_W-1:0] word_in,
    output logic [IDX_W-1:0]  idx,
    output logic              last,
    output logic [DATA_W-1:0] acc
);
    localparam int BYTES = DATA_W / 8;

    logic [DATA_W-1:0] masked;

    // Keep only the low size bytes of a full-width read.
    always_comb begin
        masked = '0;
        for (int b = 0; b < BYTES; b++) begin
            if (b < int'(size)) masked[8*b +: 8] = word_in[8*b +: 8];
        end
    end

    // Final byte of the run is reached when idx+1 equals the size.
    always_comb last = (({1'b0, idx} + SZ_W'(1)) == size);

    // Index and accumulator update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
            acc <= '0;
        end else if (clear) begin
            idx <= '0;
            acc <= '0;
        end else begin
            if (step)    idx <= idx + IDX_W'(1);
            if (capture) acc <= {acc[DATA_W-9:0], word_in[7:0]};
            else if (load) acc <= masked;
        end
    end

    // The index never advances past the widest access.
    assert_idx_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !last);
endmodule

// File: rtl/lpc_window_mapper.sv
// Top of the LPC window mapper: accepts one request at a time, checks it,
// programs firmware bank and read width on change, then issues the data
// access(es) on the internal bus. Assumes the bus returns exactly one
// bus_ack pulse per request it sees.
module lpc_window_mapper
    import lpc_map_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int SEG_SHIFT = 28,
    parameter int RSZ_LSB   = 24,
    parameter logic [ADDR_W-1:0] IO_BASE     = 32'hD001_0000,
    parameter logic [ADDR_W-1:0] MEM_BASE    = 32'hE000_0000,
    parameter logic [ADDR_W-1:0] FW_BASE     = 32'hF000_0000,
    parameter logic [ADDR_W-1:0] REG_BASE    = 32'hC001_2000,
    parameter logic [ADDR_W-1:0] SEG_REG_OFF = 32'h0000_0024,
    parameter logic [ADDR_W-1:0] RSZ_REG_OFF = 32'h0000_0028,
    parameter logic [ADDR_W:0]   IO_LIMIT    = 33'h0_0001_0000,
    parameter logic [ADDR_W:0]   MEM_LIMIT   = 33'h0_1000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_space,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_req,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [2:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int SEG_W = ADDR_W - SEG_SHIFT;
    localparam int BYTES = DATA_W / 8;
    localparam int IDX_W = $clog2(BYTES);
    localparam int SZ_W  = IDX_W + 1;
    localparam logic [ADDR_W-1:0] SEG_REG_ADDR = REG_BASE + SEG_REG_OFF;
    localparam logic [ADDR_W-1:0] RSZ_REG_ADDR = REG_BASE + RSZ_REG_OFF;

    fsm_e              st;
    logic [1:0]        r_space;
    logic [ADDR_W-1:0] r_addr;
    logic [SZ_W-1:0]   r_size;
    logic              r_write;
    logic [DATA_W-1:0] r_wdata;
    logic [DATA_W-1:0] seg_rd_q;
    rsp_e              r_status;

    logic              chk_ok;
    logic [ADDR_W-1:0] map_addr;
    logic              seg_hit, rsz_hit;
    logic              seg_set, rsz_set;
    logic [IDX_W-1:0]  idx;
    logic              last;
    logic [DATA_W-1:0] acc;
    logic              is_fw;
    logic              accept;
    logic              ack_ok;
    logic [SEG_W-1:0]  r_seg;

    always_comb begin
        is_fw  = (space_e'(r_space) == SP_FW);
        accept = (st == S_IDLE) && req_valid;
        ack_ok = bus_ack && !bus_err;
        r_seg  = r_addr[ADDR_W-1 -: SEG_W];
    end

    lpc_window_check #(
        .ADDR_W(ADDR_W), .SZ_W(SZ_W), .SEG_SHIFT(SEG_SHIFT),
        .IO_BASE(IO_BASE), .MEM_BASE(MEM_BASE), .FW_BASE(FW_BASE),
        .IO_LIMIT(IO_LIMIT), .MEM_LIMIT(MEM_LIMIT)
    ) u_check (
        .space(r_space), .addr(r_addr), .size(r_size),
        .ok(chk_ok), .map_addr(map_addr)
    );

    lpc_fw_cache #(.SEG_W(SEG_W), .SZ_W(SZ_W), .CACHE_W(8)) u_cache (
        .clk(clk), .rst_n(rst_n),
        .seg_req(r_seg), .rsz_req(r_size),
        .seg_set(seg_set), .rsz_set(rsz_set),
        .seg_hit(seg_hit), .rsz_hit(rsz_hit)
    );

    lpc_byte_seq #(.DATA_W(DATA_W), .IDX_W(IDX_W), .SZ_W(SZ_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .clear(accept),
        .step(st == S_DATA && ack_ok && !is_fw && !last),
        .capture(st == S_DATA && ack_ok && !is_fw && !r_write),
        .load(st == S_DATA && ack_ok && is_fw && !r_write),
        .size(r_size), .word_in(bus_rdata),
        .idx(idx), .last(last), .acc(acc)
    );

    // Cache update strobes follow successful register writes only.
    always_comb begin
        seg_set = (st == S_SEG_WR) && ack_ok;
        rsz_set = (st == S_RSZ_WR) && ack_ok;
    end

    // Sequencer: request capture, checking, register programming, data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            r_space  <= '0;
            r_addr   <= '0;
            r_size   <= '0;
            r_write  <= 1'b0;
            r_wdata  <= '0;
            seg_rd_q <= '0;
            r_status <= RS_OK;
        end else begin
            case (st)
                S_IDLE: if (req_valid) begin
                    r_space  <= req_space;
                    r_addr   <= req_addr;
                    r_size   <= req_size;
                    r_write  <= req_write;
                    r_wdata  <= req_wdata;
                    r_status <= RS_OK;
                    st       <= S_CHECK;
                end
                S_CHECK: begin
                    if (!chk_ok) begin
                        r_status <= RS_PARAM;
                        st       <= S_RESP;
                    end else if (is_fw && !seg_hit)             st <= S_SEG_RD;
                    else if (is_fw && !r_write && !rsz_hit)     st <= S_RSZ_WR;
                    else                                        st <= S_DATA;
                end
                S_SEG_RD: if (bus_ack) begin
                    if (bus_err) begin
                        r_status <= RS_BUS;
                        st       <= S_RESP;
                    end else begin
                        seg_rd_q <= bus_rdata;
                        st       <= S_SEG_WR;
                    end
                end
                S_SEG_WR: if (bus_ack) begin
                    if (bus_err) begin
                        r_status <= RS_BUS;
                        st       <= S_RESP;
                    end else if (!r_write && !rsz_hit) st <= S_RSZ_WR;
                    else                                st <= S_DATA;
                end
                S_RSZ_WR: if (bus_ack) begin
                    if (bus_err) begin
                        r_status <= RS_BUS;
                        st       <= S_RESP;
                    end else st <= S_DATA;
                end
                S_DATA: if (bus_ack) begin
                    if (bus_err) begin
                        r_status <= RS_BUS;
                        st       <= S_RESP;
                    end else if (is_fw || last) st <= S_RESP;
                end
                S_RESP:  st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    // Internal bus drive, decoded from the sequencer state.
    always_comb begin
        bus_req   = 1'b0;
        bus_write = 1'b0;
        bus_addr  = '0;
        bus_size  = 3'(BYTES);
        bus_wdata = '0;
        case (st)
            S_SEG_RD: begin
                bus_req  = 1'b1;
                bus_addr = SEG_REG_ADDR;
            end
            S_SEG_WR: begin
                bus_req   = 1'b1;
                bus_write = 1'b1;
                bus_addr  = SEG_REG_ADDR;
                bus_wdata = {seg_rd_q[DATA_W-1:SEG_W], r_seg};
            end
            S_RSZ_WR: begin
                bus_req   = 1'b1;
                bus_write = 1'b1;
                bus_addr  = RSZ_REG_ADDR;
                bus_wdata = DATA_W'(rsz_code(3'(r_size))) << RSZ_LSB;
            end
            S_DATA: begin
                bus_req   = 1'b1;
                bus_write = r_write;
                if (is_fw) begin
                    bus_addr  = map_addr;
                    bus_size  = 3'(r_size);
                    bus_wdata = r_wdata;
                end else begin
                    bus_addr  = map_addr + ADDR_W'(idx);
                    bus_size  = 3'd1;
                    bus_wdata = DATA_W'(r_wdata[{idx, 3'b000} +: 8]);
                end
            end
            default: ;
        endcase
    end

    // Response outputs.
    always_comb begin
        busy       = (st != S_IDLE);
        rsp_valid  = (st == S_RESP);
        rsp_status = r_status;
        rsp_rdata  = acc;
    end

    // A pending bus access keeps its address and direction until acknowledged.
    assert_bus_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_write)));

    // The response strobe lasts one cycle.
    assert_rsp_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // A request that fails the window check never reaches the bus.
    assert_param_nobus_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_CHECK && !chk_ok) |=> (!bus_req && rsp_valid));

    // I/O and memory data accesses are single bytes.
    assert_byte_size_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && st == S_DATA && !is_fw) |-> (bus_size == 3'd1));
endmodule

// File: tb/sim_lpc_window_mapper.sv
module sim_lpc_window_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_space = '0;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        busy, rsp_valid;
    logic [1:0]  rsp_status;
    logic [31:0] rsp_rdata;
    logic        bus_req, bus_write;
    logic [31:0] bus_addr, bus_wdata;
    logic [2:0]  bus_size;
    logic        bus_ack = 1'b0;
    logic        bus_err = 1'b0;
    logic [31:0] bus_rdata = '0;

    always #10 clk = ~clk;  // 50 MHz

    lpc_window_mapper u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_space(req_space),
        .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
        .req_wdata(req_wdata), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_status(rsp_status), .rsp_rdata(rsp_rdata), .bus_req(bus_req),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_err(bus_err),
        .bus_rdata(bus_rdata)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    // Bus model state and access log.
    logic [31:0] seg_model = 32'h1234_567A;
    logic [31:0] err_addr = '0;
    bit          err_en = 1'b0;
    bit          err_wr_only = 1'b0;
    int          nacc = 0;
    logic [31:0] log_addr [16];
    logic [31:0] log_wd   [16];
    logic [2:0]  log_sz   [16];
    logic        log_wr   [16];

    logic [1:0]  got_st;
    logic [31:0] got_rd;
    int          got_cyc;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Responder: acknowledges each access on the falling edge after it appears.
    initial forever begin
        @(negedge clk);
        if (bus_ack) begin
            bus_ack = 1'b0;
            bus_err = 1'b0;
        end else if (bus_req) begin
            if (nacc < 16) begin
                log_addr[nacc] = bus_addr;
                log_wd[nacc]   = bus_wdata;
                log_sz[nacc]   = bus_size;
                log_wr[nacc]   = bus_write;
            end
            nacc++;
            bus_err = err_en && (bus_addr == err_addr) && (bus_write || !err_wr_only);
            if (bus_addr == 32'hC001_2024)       bus_rdata = seg_model;
            else if (bus_addr[31:28] == 4'hF)    bus_rdata = bus_addr ^ 32'h0F0F_0F0F;
            else                                 bus_rdata = {24'h0, bus_addr[7:0] ^ 8'h5A};
            if (bus_write && !bus_err && bus_addr == 32'hC001_2024) seg_model = bus_wdata;
            bus_ack = 1'b1;
        end
    end

    task automatic run_req(input logic [1:0] sp, input logic [31:0] a, input logic [2:0] sz,
                           input logic wr, input logic [31:0] wd);
        @(negedge clk);
        nacc      = 0;
        req_space = sp;
        req_addr  = a;
        req_size  = sz;
        req_write = wr;
        req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        got_cyc = 1;
        while (!rsp_valid && got_cyc < 200) begin
            @(negedge clk);
            got_cyc++;
        end
        got_st = rsp_status;
        got_rd = rsp_rdata;
    endtask

    typedef struct packed {
        logic [1:0]  sp;
        logic [31:0] addr;
        logic [2:0]  sz;
        logic        wr;
        logic [31:0] wd;
        logic [1:0]  st;
        logic [31:0] rd;
        logic [4:0]  nacc;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 32'h0000_0060, 3'd1, 1'b0, 32'h0, 2'd0, 32'h0000_003A, 5'd1}, // R2 byte IO read
        '{2'd0, 32'h0000_0070, 3'd2, 1'b0, 32'h0, 2'd0, 32'h0000_2A2B, 5'd2}, // R10 two-byte assembly
        '{2'd1, 32'h0123_4500, 3'd4, 1'b0, 32'h0, 2'd0, 32'h5A5B_5859, 5'd4}, // R3 R10 memory read
        '{2'd0, 32'h0000_0100, 3'd4, 1'b1, 32'h1122_3344, 2'd0, 32'h0, 5'd4}, // R9 split write
        '{2'd0, 32'h0000_FFFF, 3'd1, 1'b0, 32'h0, 2'd0, 32'h0000_00A5, 5'd1}, // R2 top edge fits
        '{2'd0, 32'h0000_FFFF, 3'd2, 1'b0, 32'h0, 2'd1, 32'h0, 5'd0},         // R2 past IO limit
        '{2'd1, 32'h0FFF_FFFF, 3'd1, 1'b0, 32'h0, 2'd0, 32'h0000_00A5, 5'd1}, // R3 top edge fits
        '{2'd1, 32'h0FFF_FFFF, 3'd2, 1'b1, 32'h0, 2'd1, 32'h0, 5'd0},         // R3 past memory limit
        '{2'd2, 32'h1000_0010, 3'd4, 1'b0, 32'h0, 2'd0, 32'hFF0F_0F1F, 5'd4}, // R1 R7 R8 first firmware read
        '{2'd2, 32'h1000_0020, 3'd4, 1'b0, 32'h0, 2'd0, 32'hFF0F_0F2F, 5'd1}, // R7 cache hit
        '{2'd2, 32'h1000_0030, 3'd2, 1'b0, 32'h0, 2'd0, 32'h0000_0F3F, 5'd2}, // R8 width change only
        '{2'd2, 32'h2000_0000, 3'd4, 1'b1, 32'hA5A5_0001, 2'd0, 32'h0, 5'd3}, // R7 R8 write: bank only
        '{2'd2, 32'h2000_0004, 3'd2, 1'b1, 32'h0000_BEEF, 2'd0, 32'h0, 5'd1}, // R4 single firmware write
        '{2'd2, 32'h2FFF_FFFE, 3'd4, 1'b0, 32'h0, 2'd1, 32'h0, 5'd0},         // R4 bank crossing
        '{2'd2, 32'hFFFF_FFFC, 3'd4, 1'b0, 32'h0, 2'd1, 32'h0, 5'd0},         // R5 wrap
        '{2'd0, 32'h0000_0000, 3'd3, 1'b0, 32'h0, 2'd1, 32'h0, 5'd0},         // R6 illegal size
        '{2'd3, 32'h0000_0000, 3'd1, 1'b0, 32'h0, 2'd1, 32'h0, 5'd0},         // R6 illegal space
        '{2'd2, 32'h2000_0040, 3'd2, 1'b0, 32'h0, 2'd0, 32'h0000_0F4F, 5'd1}  // R8 width cached
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", 32'(busy), 32'h0);
        check("R1 rsp_valid", 32'(rsp_valid), 32'h0);
        check("R1 bus_req", 32'(bus_req), 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_req(VECS[i].sp, VECS[i].addr, VECS[i].sz, VECS[i].wr, VECS[i].wd);
            check($sformatf("vec%0d status", i), 32'(got_st), 32'(VECS[i].st));
            check($sformatf("vec%0d rdata", i), got_rd, VECS[i].rd);
            check($sformatf("vec%0d accesses", i), 32'(nacc), 32'(VECS[i].nacc));
            if (VECS[i].st == 2'd1) check($sformatf("vec%0d R6 latency", i), 32'(got_cyc), 32'd2);
        end

        // R9 byte order of a split write
        run_req(2'd0, 32'h0000_0200, 3'd2, 1'b1, 32'h0000_BEEF);
        check("R9 addr0", log_addr[0], 32'hD001_0200);
        check("R9 data0", log_wd[0], 32'h0000_00EF);
        check("R9 addr1", log_addr[1], 32'hD001_0201);
        check("R9 data1", log_wd[1], 32'h0000_00BE);
        check("R9 size", 32'(log_sz[1]), 32'd1);
        check("R9 dir", 32'(log_wr[0]), 32'd1);

        // R11 error on third byte aborts the run
        err_en = 1'b1; err_wr_only = 1'b0; err_addr = 32'hE000_0042;
        run_req(2'd1, 32'h0000_0040, 3'd4, 1'b0, 32'h0);
        check("R11 status", 32'(got_st), 32'd2);
        check("R11 accesses", 32'(nacc), 32'd3);

        // R11 failed bank write leaves the cache unchanged
        err_wr_only = 1'b1; err_addr = 32'hC001_2024;
        run_req(2'd2, 32'h5000_0000, 3'd4, 1'b1, 32'h0);
        check("R11 bank err status", 32'(got_st), 32'd2);
        check("R11 bank err accesses", 32'(nacc), 32'd2);
        err_en = 1'b0;
        run_req(2'd2, 32'h5000_0000, 3'd4, 1'b1, 32'h0);
        check("R11 bank retried", 32'(nacc), 32'd3);
        run_req(2'd2, 32'h5000_0000, 3'd4, 1'b1, 32'h0);
        check("R7 bank now cached", 32'(nacc), 32'd1);

        // R7 bank register keeps its upper bits; R4 rebased data address
        seg_model = 32'hABCD_EF07;
        run_req(2'd2, 32'h6000_0100, 3'd4, 1'b1, 32'h0102_0304);
        check("R7 reg read addr", log_addr[0], 32'hC001_2024);
        check("R7 reg write data", log_wd[1], 32'hABCD_EF06);
        check("R4 data addr", log_addr[2], 32'hF000_0100);
        check("R4 data wdata", log_wd[2], 32'h0102_0304);
        check("R4 data size", 32'(log_sz[2]), 32'd4);

        // R8 width codes
        run_req(2'd2, 32'h6000_0000, 3'd1, 1'b0, 32'h0);
        check("R8 code 1B addr", log_addr[0], 32'hC001_2028);
        check("R8 code 1B", log_wd[0], 32'h0000_0000);
        check("R10 fw byte read", got_rd, 32'h0000_000F);
        run_req(2'd2, 32'h6000_0004, 3'd4, 1'b0, 32'h0);
        check("R8 code 4B", log_wd[0], 32'h0200_0000);
        check("R8 accesses", 32'(nacc), 32'd2);

        // R12 request presented while busy is ignored
        @(negedge clk);
        nacc = 0;
        req_space = 2'd1; req_addr = 32'h0000_0080; req_size = 3'd4; req_write = 1'b0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        req_space = 2'd0; req_addr = 32'h0000_0000; req_size = 3'd1;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        got_cyc = 0;
        while (!rsp_valid && got_cyc < 200) begin
            @(negedge clk);
            got_cyc++;
        end
        check("R12 rdata", rsp_rdata, 32'hDADB_D8D9);
        repeat (6) @(negedge clk);
        check("R12 accesses", 32'(nacc), 32'd4);
        check("R12 last addr", log_addr[3], 32'hE000_0083);
        check("R12 idle", 32'(busy), 32'd0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule